// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for each received frame, whether it is kept. It looks only at the 48-bit destination address. The address arrives as one word together with a one-cycle valid strobe. Byte 0, the first byte on the wire, sits in bits 7:0 of that word.

A frame is accepted when any one of three paths accepts it:

- **Promiscuous bypass.** It accepts every frame.
- **Exact-match entries.** Each enabled entry compares the whole address against its own programmed value. One entry is normally set to all ones so that broadcast frames get through.
- **Multicast hash.** A 64-bin table is indexed by a CRC-32 of the address. It is consulted only for group addresses.

Each result carries the 6-bit hash index that was computed for the address, so software can pick table bins.

A small write-only register port programs all the filter state:

| Address | Contents |
|---|---|
| 0 | Control word |
| 1 + 3·e + w | Word w of exact entry e (w = 0 low, 1 mid, 2 high) |
| 1 + 3·NUM_EXACT + k | Hash table word k, for k = 0..3 |

With the default NUM_EXACT = 2, addresses 1–3 hold entry 0, 4–6 hold entry 1, and 7–10 hold hash words 0–3.

The register at address 0 is the control word:

| Bit | Meaning |
|---|---|
| 0 | Promiscuous enable |
| 1 | Hash enable |
| 2 + e | Enable of exact entry e |

Top module: `mcf_filter`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears all filter state and drives res_valid, res_accept and res_hash_idx to 0. Until the filter is programmed, every address, broadcast included, is rejected.
- R2: An address sampled with da_valid on clock edge N gives res_valid high for exactly one cycle, starting at edge N+1. Address processing adds no other latency.
- R3: The hash index is computed in three steps:
  - The CRC-32 is run over the six address bytes. It is seeded with all ones, uses reflected polynomial 0xEDB88320, takes byte 0 first and each byte LSB first, and has no final inversion.
  - The 32-bit result is bit-reversed, and its four bytes are then swapped end for end.
  - The index is bits 28:23 of that word.
- R4: Exact entry words hold the address byte-swapped: low = byte1:byte0, mid = byte3:byte2, high = byte5:byte4. An enabled entry whose three words equal the address accepts it.
- R5: An enabled exact entry programmed to all ones accepts the broadcast address FF:FF:FF:FF:FF:FF.
- R6: The hash path applies only when both of these hold:
  - Control bit 1 is set.
  - The address is a group address (bit 0 of byte 0 is 1).

  Index bits 5:4 select hash word 0–3, and index bits 3:0 select the bit inside that word. The address is accepted when that bit is 1.
- R7: With all four hash words written to 16'hFFFF and hashing enabled, every group address is accepted.
- R8: A unicast address is accepted only by an enabled exact entry or by promiscuous mode. A set hash bin never accepts it.
- R9: With control bit 0 set, every address is accepted.
- R10: A write to any address word of an exact entry whose enable bit is set is ignored. The entry must be disabled before it is reprogrammed.
- R11: A hash-word write that lands on the same edge as the lookup of an address uses the table contents from before the write. The next lookup sees the new contents.
- R12: res_accept and res_hash_idx hold their last values in cycles where res_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register write address (width derived from NUM_EXACT) |
| cfg_wdata | input | 16 | Register write data |
| da_valid | input | 1 | Destination address valid |
| da_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| res_valid | output | 1 | Filter result valid |
| res_accept | output | 1 | 1 = accept frame, 0 = reject |
| res_hash_idx | output | 6 | Hash index computed for the address |

## Verification
Two things can happen on the same clock edge: a register write updating a hash word, and the lookup of an address that was captured one edge earlier.

The bench provokes this by presenting a group address and placing a write to that address's hash word on the following edge. That write turns the address's bin from 0 to 1. The result must still show reject, because the lookup used the old table. A second lookup of the same address must then show accept.

The exact-entry write lock is judged the same way, at the ports. After an attempted rewrite of a locked entry, the old address must still be accepted and the attempted new one must not be.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
  localparam int MAC_W     = 48;
  localparam int CRC_W     = 32;
  localparam int WORD_W    = 16;
  localparam int HIDX_W    = 6;
  localparam int HASH_BINS = 2 ** HIDX_W;
  localparam int HASH_WRDS = HASH_BINS / WORD_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;

  typedef logic [MAC_W-1:0]  mac_t;
  typedef logic [HIDX_W-1:0] hidx_t;

  // Reflected CRC over the address, byte 0 first, LSB first. The
  // bit reversal and byte swap are folded into a fixed bit pick:
  // swapped[28]..swapped[24] come from raw bits 27..31, swapped[23]
  // from raw bit 16.
  function automatic hidx_t hash_index(input mac_t a);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = '1;
    for (int i = 0; i < MAC_W; i++) begin
      fb = c[0] ^ a[i];
      c  = {1'b0, c[CRC_W-1:1]} ^ (fb ? CRC_POLY : '0);
    end
    return {c[27], c[28], c[29], c[30], c[31], c[16]};
  endfunction
endpackage

// File: rtl/mcf_regs.sv
module mcf_regs
  import mcf_pkg::*;
#(
  parameter  int NUM_EXACT = 2,
  parameter  int CFG_AW    = 4,
  localparam int CTRL_W    = 2 + NUM_EXACT,
  localparam int HASH_BASE = 1 + 3 * NUM_EXACT
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [CFG_AW-1:0]                cfg_addr,
  input  logic [WORD_W-1:0]                cfg_wdata,
  output logic                             promisc_en,
  output logic                             hash_en,
  output logic [NUM_EXACT-1:0]             ex_en,
  output logic [NUM_EXACT-1:0][MAC_W-1:0]  ex_addr,
  output logic [HASH_BINS-1:0]             hash_tbl
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (cfg_we && cfg_addr == '0) ctrl_d = cfg_wdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign promisc_en = ctrl_q[0];
  assign hash_en    = ctrl_q[1];
  assign ex_en      = ctrl_q[CTRL_W-1:2];

  // Exact entries: three byte-swapped words each, locked while enabled.
  for (genvar e = 0; e < NUM_EXACT; e++) begin : g_entry
    for (genvar w = 0; w < 3; w++) begin : g_word
      logic [WORD_W-1:0] word_q, word_d;
      logic              wsel;
      assign wsel = cfg_we && !ctrl_q[2+e] &&
                    (cfg_addr == CFG_AW'(1 + 3 * e + w));
      always_comb begin
        word_d = word_q;
        if (wsel) word_d = cfg_wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
      end
      assign ex_addr[e][WORD_W*w +: WORD_W] = word_q;
    end
  end

  // Hash table words, word k holds bins 16k..16k+15.
  for (genvar k = 0; k < HASH_WRDS; k++) begin : g_hash
    logic [WORD_W-1:0] hw_q, hw_d;
    logic              hsel;
    assign hsel = cfg_we && (cfg_addr == CFG_AW'(HASH_BASE + k));
    always_comb begin
      hw_d = hw_q;
      if (hsel) hw_d = cfg_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hw_q <= '0;
      else        hw_q <= hw_d;
    end
    assign hash_tbl[WORD_W*k +: WORD_W] = hw_q;
  end
endmodule

// File: rtl/mcf_exact.sv
module mcf_exact
  import mcf_pkg::*;
#(
  parameter int NUM_EXACT = 2
) (
  input  mac_t                            addr,
  input  logic [NUM_EXACT-1:0]            ex_en,
  input  logic [NUM_EXACT-1:0][MAC_W-1:0] ex_addr,
  output logic                            hit
);
  logic [NUM_EXACT-1:0] hit_vec;

  for (genvar e = 0; e < NUM_EXACT; e++) begin : g_cmp
    assign hit_vec[e] = ex_en[e] && (ex_addr[e] == addr);
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/mcf_hash.sv
module mcf_hash
  import mcf_pkg::*;
(
  input  mac_t                 addr,
  input  logic [HASH_BINS-1:0] hash_tbl,
  output hidx_t                idx,
  output logic                 bin_set
);
  // Index bits 5:4 pick the word and 3:0 the bit, which is the flat bin.
  assign idx     = hash_index(addr);
  assign bin_set = hash_tbl[idx];
endmodule

// File: rtl/mcf_filter.sv
module mcf_filter
  import mcf_pkg::*;
#(
  parameter  int NUM_EXACT = 2,
  localparam int CFG_AW    = $clog2(1 + 3 * NUM_EXACT + HASH_WRDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [15:0]       cfg_wdata,
  input  logic              da_valid,
  input  logic [47:0]       da_addr,
  output logic              res_valid,
  output logic              res_accept,
  output logic [5:0]        res_hash_idx
);
  logic                            promisc_en, hash_en;
  logic [NUM_EXACT-1:0]            ex_en;
  logic [NUM_EXACT-1:0][MAC_W-1:0] ex_addr;
  logic [HASH_BINS-1:0]            hash_tbl;

  mcf_regs #(.NUM_EXACT(NUM_EXACT), .CFG_AW(CFG_AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .promisc_en(promisc_en), .hash_en(hash_en),
    .ex_en(ex_en), .ex_addr(ex_addr), .hash_tbl(hash_tbl)
  );

  // Capture stage
  logic s1_valid_q, s1_valid_d;
  mac_t s1_addr_q, s1_addr_d;

  always_comb begin
    s1_valid_d = da_valid;
    s1_addr_d  = da_valid ? da_addr : s1_addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_addr_q  <= '0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s1_addr_q  <= s1_addr_d;
    end
  end

  // Decision stage
  logic  exact_hit, bin_set;
  hidx_t idx;

  mcf_exact #(.NUM_EXACT(NUM_EXACT)) exact_i (
    .addr(s1_addr_q), .ex_en(ex_en), .ex_addr(ex_addr), .hit(exact_hit)
  );

  mcf_hash hash_i (
    .addr(s1_addr_q), .hash_tbl(hash_tbl), .idx(idx), .bin_set(bin_set)
  );

  logic  is_group, hash_hit, decide;
  assign is_group = s1_addr_q[0];
  assign hash_hit = hash_en && is_group && bin_set;
  assign decide   = promisc_en || exact_hit || hash_hit;

  logic  res_valid_q, res_valid_d, res_accept_q, res_accept_d;
  hidx_t res_idx_q, res_idx_d;

  always_comb begin
    res_valid_d  = s1_valid_q;
    res_accept_d = res_accept_q;
    res_idx_d    = res_idx_q;
    if (s1_valid_q) begin
      res_accept_d = decide;
      res_idx_d    = idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_q  <= 1'b0;
      res_accept_q <= 1'b0;
      res_idx_q    <= '0;
    end else begin
      res_valid_q  <= res_valid_d;
      res_accept_q <= res_accept_d;
      res_idx_q    <= res_idx_d;
    end
  end

  assign res_valid    = res_valid_q;
  assign res_accept   = res_accept_q;
  assign res_hash_idx = res_idx_q;
endmodule

// File: rtl/mcf_filter_chk.sv
module mcf_filter_chk
  import mcf_pkg::*;
#(
  parameter int NUM_EXACT = 2
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            da_valid,
  input logic                            res_valid,
  input logic                            res_accept,
  input logic [5:0]                      res_hash_idx,
  input logic                            promisc_en,
  input logic                            group_bit,
  input logic                            exact_hit,
  input logic [NUM_EXACT-1:0]            ex_en,
  input logic [NUM_EXACT-1:0][MAC_W-1:0] ex_addr
);
  p_result_after_two_edges_r2: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> ##1 res_valid);

  p_no_spurious_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> ##1 !res_valid);

  p_promisc_accepts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(promisc_en)) |-> res_accept);

  p_unicast_needs_exact_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !$past(promisc_en) && !$past(group_bit) && !$past(exact_hit))
      |-> !res_accept);

  p_outputs_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_hash_idx) && $stable(res_accept)));

  for (genvar e = 0; e < NUM_EXACT; e++) begin : g_lock
    p_entry_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ex_en[e]) |-> $stable(ex_addr[e]));
  end
endmodule

bind mcf_filter mcf_filter_chk #(.NUM_EXACT(NUM_EXACT)) chk_i (
  .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .res_valid(res_valid),
  .res_accept(res_accept), .res_hash_idx(res_hash_idx),
  .promisc_en(promisc_en), .group_bit(s1_addr_q[0]), .exact_hit(exact_hit),
  .ex_en(ex_en), .ex_addr(ex_addr)
);

// File: tb/mcf_filter_tb_top.sv
`timescale 1ns/1ps
module mcf_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        da_valid;
  logic [47:0] da_addr;
  logic        res_valid, res_accept;
  logic [5:0]  res_hash_idx;

  always #2 clk = ~clk;

  mcf_filter #(.NUM_EXACT(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da_addr(da_addr),
    .res_valid(res_valid), .res_accept(res_accept),
    .res_hash_idx(res_hash_idx)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] STATION = 48'h5E4D_3C2B_1A02;
  localparam logic [47:0] MC_A    = 48'h0000_005E_0001;
  localparam logic [47:0] UC_A    = 48'h6655_4433_2210;
  localparam logic [47:0] VEC [8] = '{
    BCAST, STATION, MC_A, 48'h0100_005E_0001,
    48'h0000_0001_3333, UC_A, 48'h0C0B_0A09_0806, 48'hFEED_FACE_CAFB
  };

  // Shadow of programmed state, built from the register map in the brief
  logic [3:0]  sh_ctrl;
  logic [47:0] sh_ex [2];
  logic [63:0] sh_tbl;

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c, r, s;
    c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      c ^= {24'h0, a[8*b +: 8]};
      for (int k = 0; k < 8; k++)
        c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    for (int i = 0; i < 32; i++) r[i] = c[31-i];
    s = {r[7:0], r[15:8], r[23:16], r[31:24]};
    return s[28:23];
  endfunction

  function automatic logic ref_accept(input logic [47:0] a);
    logic acc;
    acc = sh_ctrl[0];
    for (int e = 0; e < 2; e++)
      if (sh_ctrl[2+e] && sh_ex[e] == a) acc = 1'b1;
    if (sh_ctrl[1] && a[0] && sh_tbl[ref_idx(a)]) acc = 1'b1;
    return acc;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    if (a == 4'd0) sh_ctrl = d[3:0];
    else if (a <= 4'd6) begin
      if (!sh_ctrl[2 + (a-1)/3]) sh_ex[(a-1)/3][16*((a-1)%3) +: 16] = d;
    end else if (a <= 4'd10) sh_tbl[16*(a-7) +: 16] = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(input logic [47:0] a, input string req);
    logic [5:0] ei;
    logic       ea;
    ei = ref_idx(a);
    ea = ref_accept(a);
    @(negedge clk);
    da_valid = 1'b1; da_addr = a;
    @(posedge clk);
    @(negedge clk);
    da_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R2", res_valid, 1);
    chk(req, res_accept, ea);
    chk("R3", res_hash_idx, ei);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] hold_idx;
    logic [5:0] mi;
    sh_ctrl = '0; sh_ex[0] = '0; sh_ex[1] = '0; sh_tbl = '0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    da_valid = 1'b0; da_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", {res_valid, res_accept, res_hash_idx}, 0);
    rst_n = 1'b1;
    look(BCAST, "R1");

    // Program: broadcast entry, station entry, two hash bins
    wr(4'd1, 16'hFFFF); wr(4'd2, 16'hFFFF); wr(4'd3, 16'hFFFF);
    wr(4'd4, 16'h1A02); wr(4'd5, 16'h3C2B); wr(4'd6, 16'h5E4D);
    begin
      logic [63:0] t;
      t = '0;
      t[ref_idx(MC_A)] = 1'b1;
      t[ref_idx(UC_A)] = 1'b1;
      for (int k = 0; k < 4; k++) wr(4'(7 + k), t[16*k +: 16]);
    end
    wr(4'd0, 16'h000E);
    look(BCAST, "R5");
    look(STATION, "R4");
    look(MC_A, "R6");
    look(UC_A, "R8");
    for (int v = 0; v < 8; v++) look(VEC[v], "R6");

    // R12: outputs hold while no result is produced
    hold_idx = ref_idx(VEC[7]);
    repeat (3) @(negedge clk);
    chk("R12", {res_valid, res_hash_idx}, {1'b0, hold_idx});

    // R10: locked entry ignores writes, then reprogram after disable
    wr(4'd4, 16'h0000);
    look(STATION, "R10");
    wr(4'd0, 16'h0006);
    wr(4'd4, 16'h1A04);
    wr(4'd0, 16'h000E);
    look(48'h5E4D_3C2B_1A04, "R10");
    look(STATION, "R10");

    // R6: hash disabled leaves group address to exact entries only
    wr(4'd0, 16'h000C);
    look(MC_A, "R6");
    look(BCAST, "R5");

    // R7 and R8: all-ones table
    for (int k = 0; k < 4; k++) wr(4'(7 + k), 16'hFFFF);
    wr(4'd0, 16'h000E);
    for (int v = 0; v < 8; v++) look(VEC[v], "R7");
    look(48'h0C0B_0A09_0806, "R8");

    // R9: promiscuous
    wr(4'd0, 16'h0001);
    look(48'h0C0B_0A09_0806, "R9");
    look(48'hFEED_FACE_CAFB, "R9");

    // R11: hash write on the same edge as the lookup
    for (int k = 0; k < 4; k++) wr(4'(7 + k), 16'h0000);
    wr(4'd0, 16'h0002);
    mi = ref_idx(MC_A);
    @(negedge clk);
    da_valid = 1'b1; da_addr = MC_A;
    @(posedge clk);
    @(negedge clk);
    da_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = 4'(7 + mi[5:4]); cfg_wdata = 16'hFFFF;
    @(posedge clk);
    sh_tbl[16*mi[5:4] +: 16] = 16'hFFFF;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R11", {res_valid, res_accept}, 2'b10);
    look(MC_A, "R11");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule